// File: doc/BRIEF.md
# Shared Fetch/Data Memory Port Sequencer

This block lets a simple processor datapath run both instruction fetch and load/store traffic through one single-ported word memory of 1024 x 32 bits. The block contains the memory. It splits every processor cycle into two halves of one block clock each. In the fetch half, the memory address comes from the instruction address and the fetched word is captured. In the data half, the address comes from the data address. A read or a write takes place in the data half only when a load or a store was requested.

A 2:1 address multiplexer feeds the single word index. A resolved shared data bus takes the place of tristate pins. The memory drives the bus only while its output enable is on. The store-data driver drives the bus only during a store half. The processor presents a new address set after each clock edge at which `cycle_end` was high. It holds `instr_addr` until the end of the fetch half, and `data_addr`, `store_data`, `load_req` and `store_req` until the end of the data half.

The controller has five states:

- `SQ_BOOT` is held during reset and lasts one clock after it.
- `SQ_FETCH` is the fetch half.
- `SQ_LOAD`, `SQ_STORE` and `SQ_IDLE` are the three data-half variants.

It makes these transitions:

- boot→fetch.
- fetch→store when `store_req` is high.
- fetch→load when `load_req` is high and `store_req` is low.
- fetch→idle when neither request is high.
- Every data-half state returns to fetch.

Top module: `smem_shared_port`

## Requirements
- R1: While reset is high and for one clock after it falls, the block is in the boot state. `cycle_end` is 1, and `instr_word` and `load_data` read 0. The first fetch half follows.
- R2: After boot, fetch halves (`cycle_end`=0) and data halves (`cycle_end`=1) strictly alternate, one clock each.
- R3: `instr_word` takes the memory word at index `instr_addr[11:2]` at the clock edge that ends the fetch half. It then holds that value through the data half and the next fetch half.
- R4: When `load_req` is high and `store_req` is low at the end of the fetch half, the data half reads index `data_addr[11:2]`. `load_data` takes that word at the edge ending the data half and holds it at all other times.
- R5: When `store_req` is high at the end of the fetch half, `store_data` is written to index `data_addr[11:2]` at the edge ending the data half. Later fetches and loads see the new value.
- R6: A fetch in the same cycle as a store to the same word returns the contents from before the store.
- R7: When `load_req` and `store_req` are both high, the store is performed and `load_data` is left unchanged.
- R8: With neither request, the data half touches no memory word and leaves `load_data` unchanged.
- R9: Address bits outside [11:2] are ignored, so addresses differing only there reach the same word.
- R10: The memory output enable and the store-data driver are never active together. The memory write enable is high only in a store half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, two per processor cycle |
| rst | input | 1 | Synchronous reset, active high |
| instr_addr | input | 32 | Byte address of the instruction to fetch |
| data_addr | input | 32 | Byte address for the load or store |
| load_req | input | 1 | Load requested this cycle |
| store_req | input | 1 | Store requested this cycle |
| store_data | input | 32 | Word to write on a store |
| instr_word | output | 32 | Fetched instruction word |
| load_data | output | 32 | Word returned by the last load |
| cycle_end | output | 1 | High during the data half (and boot); new inputs follow its edge |

## Verification
The bench fetches a word in the same cycle that a store overwrites it. A sequencer that ran the data access first would return the new word too early. It issues a load and a store together. A design without store priority would corrupt `load_data` or drop the write. It uses aliased addresses with junk in the upper and byte bits, which expose any decode that uses the wrong bits. It also checks `instr_word` and `load_data` in the halves where they must hold. A design that captured on the wrong edge would change them while the other access owns the port.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [2:0] {
        SQ_BOOT  = 3'd0,
        SQ_FETCH = 3'd1,
        SQ_LOAD  = 3'd2,
        SQ_STORE = 3'd3,
        SQ_IDLE  = 3'd4
    } sq_state_e;

    function automatic logic is_data_half(input sq_state_e s);
        return (s == SQ_LOAD) || (s == SQ_STORE) || (s == SQ_IDLE);
    endfunction

endpackage

// File: rtl/smem_phase_fsm.sv
module smem_phase_fsm
    import smem_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_req,
    input  logic      store_req,
    output sq_state_e state,
    output logic      sel_data,
    output logic      mem_oe,
    output logic      wr_drv,
    output logic      mem_we,
    output logic      cap_instr,
    output logic      cap_load,
    output logic      cycle_end
);

    sq_state_e state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_BOOT;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_BOOT:  state_nx = SQ_FETCH;
            SQ_FETCH: begin
                if (store_req)     state_nx = SQ_STORE;
                else if (load_req) state_nx = SQ_LOAD;
                else               state_nx = SQ_IDLE;
            end
            SQ_LOAD:  state_nx = SQ_FETCH;
            SQ_STORE: state_nx = SQ_FETCH;
            SQ_IDLE:  state_nx = SQ_FETCH;
            default:  state_nx = SQ_BOOT;
        endcase
    end

    always_comb begin
        sel_data  = 1'b0;
        mem_oe    = 1'b0;
        wr_drv    = 1'b0;
        mem_we    = 1'b0;
        cap_instr = 1'b0;
        cap_load  = 1'b0;
        cycle_end = 1'b0;
        unique case (state)
            SQ_BOOT: cycle_end = 1'b1;
            SQ_FETCH: begin
                mem_oe    = 1'b1;
                cap_instr = 1'b1;
            end
            SQ_LOAD: begin
                sel_data  = 1'b1;
                mem_oe    = 1'b1;
                cap_load  = 1'b1;
                cycle_end = 1'b1;
            end
            SQ_STORE: begin
                sel_data  = 1'b1;
                wr_drv    = 1'b1;
                mem_we    = 1'b1;
                cycle_end = 1'b1;
            end
            SQ_IDLE: begin
                sel_data  = 1'b1;
                cycle_end = 1'b1;
            end
            default: cycle_end = 1'b1;
        endcase
    end

    // R2: halves alternate
    p_fetch_then_data_r2: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_FETCH) |=> is_data_half(state));
    p_data_then_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_FETCH) |=> (state == SQ_FETCH));
    // R7: store wins over load
    p_store_priority_r7: assert property (@(posedge clk) disable iff (rst)
        ((state == SQ_FETCH) && store_req) |=> (state == SQ_STORE));

endmodule

// File: rtl/smem_port_mux.sv
module smem_port_mux #(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 10,
    parameter int WORD_LSB = 2
) (
    input  logic              sel_data,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic [ADDR_W-1:0] data_addr,
    output logic [IDX_W-1:0]  word_idx
);

    localparam int IDX_HI = WORD_LSB + IDX_W - 1;

    logic [ADDR_W-1:0] picked;
    logic              unused_addr_bits;

    assign picked   = sel_data ? data_addr : instr_addr;
    assign word_idx = picked[IDX_HI:WORD_LSB];

    generate
        if (WORD_LSB > 0 && IDX_HI < ADDR_W - 1) begin : g_both
            assign unused_addr_bits = ^{picked[ADDR_W-1:IDX_HI+1], picked[WORD_LSB-1:0]};
        end else if (WORD_LSB > 0) begin : g_low
            assign unused_addr_bits = ^picked[WORD_LSB-1:0];
        end else if (IDX_HI < ADDR_W - 1) begin : g_high
            assign unused_addr_bits = ^picked[ADDR_W-1:IDX_HI+1];
        end else begin : g_none
            assign unused_addr_bits = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/smem_word_array.sv
module smem_word_array #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              oe,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wdata;
    end

    assign rdata = oe ? cells[idx] : '0;

endmodule

// File: rtl/smem_shared_port.sv
module smem_shared_port
    import smem_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic              load_req,
    input  logic              store_req,
    input  logic [DATA_W-1:0] store_data,
    output logic [DATA_W-1:0] instr_word,
    output logic [DATA_W-1:0] load_data,
    output logic              cycle_end
);

    localparam int IDX_W    = $clog2(DEPTH);
    localparam int WORD_LSB = $clog2(DATA_W / 8);

    sq_state_e         state;
    logic              sel_data, mem_oe, wr_drv, mem_we, cap_instr, cap_load;
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] mem_rdata, shared_bus;
    logic [DATA_W-1:0] instr_q, load_q;

    smem_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .load_req  (load_req),
        .store_req (store_req),
        .state     (state),
        .sel_data  (sel_data),
        .mem_oe    (mem_oe),
        .wr_drv    (wr_drv),
        .mem_we    (mem_we),
        .cap_instr (cap_instr),
        .cap_load  (cap_load),
        .cycle_end (cycle_end)
    );

    smem_port_mux #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .WORD_LSB (WORD_LSB)
    ) u_mux (
        .sel_data   (sel_data),
        .instr_addr (instr_addr),
        .data_addr  (data_addr),
        .word_idx   (word_idx)
    );

    smem_word_array #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .oe    (mem_oe),
        .idx   (word_idx),
        .wdata (shared_bus),
        .rdata (mem_rdata)
    );

    // Resolved shared bus: store driver or memory read-out, one at a time.
    assign shared_bus = wr_drv ? store_data : mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_q <= '0;
            load_q  <= '0;
        end else begin
            if (cap_instr) instr_q <= shared_bus;
            if (cap_load)  load_q  <= shared_bus;
        end
    end

    assign instr_word = instr_q;
    assign load_data  = load_q;

    // R10: bus contention and write-enable gating
    p_no_contention_r10: assert property (@(posedge clk) disable iff (rst)
        !(mem_oe && wr_drv));
    p_we_in_store_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (sel_data && wr_drv));
    // R3: instruction word holds across the data half
    p_instr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> $stable(instr_word));
    // R4: load data only moves at the end of a data half
    p_load_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !cycle_end |=> $stable(load_data));
    // R1: boot half leads straight into a fetch half
    p_boot_exit_r1: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_BOOT) |=> !cycle_end);

endmodule

// File: tb/smem_shared_port_tb_top.sv
module smem_shared_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_addr = '0, data_addr = '0, store_data = '0;
    logic        load_req = 1'b0, store_req = 1'b0;
    logic [31:0] instr_word, load_data;
    logic        cycle_end;

    always #10 clk = ~clk;

    smem_shared_port dut_i (
        .clk        (clk),
        .rst        (rst),
        .instr_addr (instr_addr),
        .data_addr  (data_addr),
        .load_req   (load_req),
        .store_req  (store_req),
        .store_data (store_data),
        .instr_word (instr_word),
        .load_data  (load_data),
        .cycle_end  (cycle_end)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [31:0] ref_mem [1024];
    bit          ref_ok  [1024];
    logic [31:0] exp_instr = '0;
    logic [31:0] exp_load = '0;
    bit          instr_known = 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge inside a fetch half; returns at the next fetch-half negedge.
    task automatic cyc(input logic [31:0] ia, input logic [31:0] da,
                       input bit ld, input bit st, input logic [31:0] wd, input string tag);
        int fi, di;
        instr_addr = ia; data_addr = da; load_req = ld; store_req = st; store_data = wd;
        chk({"R2 fetch half ", tag}, {31'd0, cycle_end}, 32'd0);
        chk({"R4 load_data held ", tag}, load_data, exp_load);
        if (instr_known) chk({"R3 instr held ", tag}, instr_word, exp_instr);
        fi = int'(ia[11:2]);
        di = int'(da[11:2]);
        instr_known = ref_ok[fi];
        exp_instr   = ref_mem[fi];
        if (st) begin
            ref_mem[di] = wd;
            ref_ok[di]  = 1;
        end else if (ld) begin
            exp_load = ref_mem[di];
        end
        @(negedge clk);
        chk({"R2 data half ", tag}, {31'd0, cycle_end}, 32'd1);
        if (instr_known) chk({"R3 fetch ", tag}, instr_word, exp_instr);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < 1024; i++) begin ref_ok[i] = 0; ref_mem[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R1 boot cycle_end", {31'd0, cycle_end}, 32'd1);
        chk("R1 reset instr", instr_word, 32'd0);
        chk("R1 reset load", load_data, 32'd0);
        rst = 1'b0;
        chk("R1 boot after release", {31'd0, cycle_end}, 32'd1);
        @(negedge clk);
        instr_known = 1; exp_instr = '0;
        // populate words 0..3 (R5)
        cyc(32'h0, 32'h000, 0, 1, 32'hA000_0000, "st0");
        cyc(32'h0, 32'h004, 0, 1, 32'hA111_1111, "R5 st1");
        cyc(32'h4, 32'h008, 0, 1, 32'hA222_2222, "st2");
        cyc(32'h8, 32'h00C, 0, 1, 32'hA333_3333, "st3");
        // R4 load
        cyc(32'h8, 32'h004, 1, 0, 32'h0, "R4 ld1");
        // R8 idle with junk write data
        cyc(32'hC, 32'h000, 0, 0, 32'hDEAD_BEEF, "R8 idle");
        cyc(32'h0, 32'h000, 1, 0, 32'h0, "R8 word0 intact");
        // R6 fetch of word being stored returns old
        cyc(32'h0, 32'h000, 0, 1, 32'hB000_0000, "R6 same-word");
        cyc(32'h0, 32'h000, 1, 0, 32'h0, "R5 new visible");
        // R7 load and store together
        cyc(32'h4, 32'h008, 1, 1, 32'hC222_2222, "R7 both");
        cyc(32'h4, 32'h010, 0, 0, 32'h0, "R7 load_data kept");
        // R9 aliasing through upper and byte bits
        cyc(32'h0000_1009, 32'hFFFF_F00E, 1, 0, 32'h0, "R9 alias ld");
        cyc(32'h8000_0000, 32'h8000_0007, 0, 1, 32'hD111_1111, "R9 alias st");
        cyc(32'h0000_2004, 32'h0000_0004, 1, 0, 32'h0, "R9 alias fetch");
        // mixed traffic
        lcg = 32'h1234_5678;
        for (int k = 0; k < 40; k++) begin
            logic [31:0] a1, a2;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            a1 = {20'h0, 6'h0, lcg[7:4], 2'b00};
            a2 = {20'h0, 6'h0, lcg[11:8], 2'b00};
            if (!ref_ok[a1[11:2]]) a1 = 32'h0;
            if (lcg[13] || !ref_ok[a2[11:2]])
                cyc(a1, a2, 0, 1, lcg ^ 32'h5A5A_0000, "R5 mix st");
            else if (lcg[14])
                cyc(a1, a2, 1, 0, 32'h0, "R4 mix ld");
            else
                cyc(a1, a2, 0, 0, lcg, "R8 mix idle");
        end
        cyc(32'h0, 32'h0, 0, 0, 32'h0, "final");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule